// File: doc/BRIEF.md
# GPIO Controller with Routed Line Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 lines on a simple 32-bit register bus. Software sets each line's direction and output value, reads back the synchronized pin levels, and picks an interrupt condition per line. The condition can be a low level, a high level, a falling edge or a rising edge.

A per-line routing byte sends each line's interrupt condition to one of several shared interrupt outputs, or to none. Each interrupt output is the OR of every unmasked line routed to it. The bus is a single-cycle write and combinational read interface. A write happens on a clock edge where `bus_valid` and `bus_write` are high. Read data follows `bus_addr` in the same cycle. Only word-aligned addresses (address bits 1:0 equal to zero) decode.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the output, direction, mask, polarity, edge and routing registers and the input synchronizer. After reset `pin_out`, `pin_oe` and `irq_o` are zero.
- R2: The output register sits at 0x04 and drives `pin_out`. The direction register sits at 0x08 and drives `pin_oe`, where 1 means output. Both read back what was written.
- R3: The data register at 0x00 returns `pin_in` through a two-flop synchronizer. A pin change made before clock edge k shows up after edge k+1. Writes to 0x00 are ignored and change no register or output.
- R4: Register bits at or above `NUM_LINES` read as zero.
- R5: Level triggering uses the polarity register at 0x10 and the edge register at 0x14, with bit n for line n. Edge 0 with polarity 0 fires while the synchronized pin is low. Edge 0 with polarity 1 fires while it is high. The routed output stays high for as long as the condition holds.
- R6: Edge triggering uses edge bit 1. Polarity 1 selects a rising edge and polarity 0 a falling edge. The edge is found by comparing the synchronized value with its value one cycle earlier. A single pin change gives a pulse exactly one clock cycle long on the routed output.
- R7: The interrupt mask register sits at 0x0C. A line whose mask bit is 0 never asserts any interrupt output.
- R8: Routing words start at 0x20 and hold four lines each, one byte per line: line n is in byte n%4 of the word at 0x20+4*(n/4). Byte bit 7 enables the route and bits 4:0 select the output index. The byte reads back with bits 6:5 as zero. Each interrupt output is the OR of all lines routed to it.
- R9: A routing byte with bit 7 clear, or with an index at or above `NUM_IRQ`, leaves the line unrouted, so it drives no output.
- R10: Reads of 0x18, 0x1C and any address past the last routing word return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| pin_in | input | NUM_LINES | Pad input levels |
| pin_out | output | NUM_LINES | Pad output values |
| pin_oe | output | NUM_LINES | Pad output enables |
| irq_o | output | NUM_IRQ | Routed interrupt outputs |

## Verification
A stale synchronizer stage or a wrong previous-value flop appears on `irq_o` within one to three cycles of a pin change. It shows as an edge pulse that comes late, lasts two cycles or never comes. A corrupted routing byte or mask bit moves or drops an interrupt on the very next cycle the line's condition holds. The bench compares `irq_o` against a model on every cycle of a long random run, so such errors are caught within a few cycles. Register faults show as soon as the affected word is read back or drives `pin_out` and `pin_oe`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam logic [7:0] OFF_DATA  = 8'h00;
    localparam logic [7:0] OFF_OUT   = 8'h04;
    localparam logic [7:0] OFF_DIR   = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h0C;
    localparam logic [7:0] OFF_POL   = 8'h10;
    localparam logic [7:0] OFF_EDGE  = 8'h14;
    localparam logic [7:0] OFF_ROUTE = 8'h20;

    // {edge, polarity}
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    typedef struct packed {
        logic       en;
        logic [4:0] idx;
    } route_t;

    function automatic route_t route_decode(input logic [7:0] b);
        route_t r;
        r.en  = b[7];
        r.idx = b[4:0];
        return r;
    endfunction

    function automatic logic [7:0] route_encode(input route_t r);
        return {r.en, 2'b00, r.idx};
    endfunction

    function automatic logic trig_hit(input trig_e t, input logic cur, input logic prev);
        case (t)
            TRIG_LOW:  return ~cur;
            TRIG_HIGH: return cur;
            TRIG_FALL: return ~cur & prev;
            default:   return cur & ~prev;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] cur_o,
    output logic [NUM_LINES-1:0] prev_o
);
    logic [NUM_LINES-1:0] meta_q, cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0] cur_i,
    input  logic [NUM_LINES-1:0] prev_i,
    input  logic [NUM_LINES-1:0] pol_sel,
    input  logic [NUM_LINES-1:0] edge_sel,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] hit_o
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        trig_e kind;
        assign kind     = trig_e'({edge_sel[i], pol_sel[i]});
        assign hit_o[i] = mask_i[i] & trig_hit(kind, cur_i[i], prev_i[i]);
    end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 4
) (
    input  logic [NUM_LINES-1:0]         hit_i,
    input  route_t [NUM_LINES-1:0]       route_i,
    output logic [NUM_IRQ-1:0]           irq_o
);
    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_out
        always_comb begin
            irq_o[j] = 1'b0;
            for (int i = 0; i < NUM_LINES; i++) begin
                if (hit_i[i] && route_i[i].en && route_i[i].idx == 5'(j))
                    irq_o[j] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic [NUM_IRQ-1:0]   irq_o
);
    localparam int ROUTE_WORDS = (NUM_LINES + 3) / 4;
    localparam int WORD_W      = ADDR_W - 2;

    logic [NUM_LINES-1:0] out_q, dir_q, mask_q, pol_q, edge_q;
    route_t [NUM_LINES-1:0] route_q;
    logic [NUM_LINES-1:0] cur, prev, hit;

    logic              aligned, wr_en, route_sel;
    logic [WORD_W-1:0] route_word;

    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign wr_en      = bus_valid & bus_write & aligned;
    assign route_word = bus_addr[ADDR_W-1:2] - WORD_W'(OFF_ROUTE >> 2);
    assign route_sel  = aligned && (bus_addr >= ADDR_W'(OFF_ROUTE))
                        && (route_word < WORD_W'(ROUTE_WORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '0;
            mask_q  <= '0;
            pol_q   <= '0;
            edge_q  <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(OFF_OUT):  out_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_W'(OFF_DIR):  dir_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_W'(OFF_MASK): mask_q <= bus_wdata[NUM_LINES-1:0];
                ADDR_W'(OFF_POL):  pol_q  <= bus_wdata[NUM_LINES-1:0];
                ADDR_W'(OFF_EDGE): edge_q <= bus_wdata[NUM_LINES-1:0];
                default: begin
                    for (int i = 0; i < NUM_LINES; i++) begin
                        if (route_sel && route_word == WORD_W'(i / 4))
                            route_q[i] <= route_decode(bus_wdata[(i % 4) * 8 +: 8]);
                    end
                end
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr)
                ADDR_W'(OFF_DATA): bus_rdata = 32'(cur);
                ADDR_W'(OFF_OUT):  bus_rdata = 32'(out_q);
                ADDR_W'(OFF_DIR):  bus_rdata = 32'(dir_q);
                ADDR_W'(OFF_MASK): bus_rdata = 32'(mask_q);
                ADDR_W'(OFF_POL):  bus_rdata = 32'(pol_q);
                ADDR_W'(OFF_EDGE): bus_rdata = 32'(edge_q);
                default: begin
                    for (int i = 0; i < NUM_LINES; i++) begin
                        if (route_sel && route_word == WORD_W'(i / 4))
                            bus_rdata[(i % 4) * 8 +: 8] = route_encode(route_q[i]);
                    end
                end
            endcase
        end
    end

    gpio_in_sync #(.NUM_LINES(NUM_LINES)) sync_i (
        .clk(clk), .rst(rst), .pin_i(pin_in), .cur_o(cur), .prev_o(prev)
    );

    gpio_trig_detect #(.NUM_LINES(NUM_LINES)) trig_i (
        .cur_i(cur), .prev_i(prev), .pol_sel(pol_q), .edge_sel(edge_q),
        .mask_i(mask_q), .hit_o(hit)
    );

    gpio_irq_router #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) route_i (
        .hit_i(hit), .route_i(route_q), .irq_o(irq_o)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_IRQ   = 4,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_IRQ-1:0]   irq_o
);
    logic wr_data, wr_out, wr_dir;
    assign wr_data = bus_valid && bus_write && bus_addr == ADDR_W'(OFF_DATA);
    assign wr_out  = bus_valid && bus_write && bus_addr == ADDR_W'(OFF_OUT);
    assign wr_dir  = bus_valid && bus_write && bus_addr == ADDR_W'(OFF_DIR);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0 && mask_q == '0));

    a_r2_out_drives_pins: assert property (@(posedge clk) disable iff (rst)
        wr_out |=> pin_out == $past(bus_wdata[NUM_LINES-1:0]));

    a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> pin_oe == $past(bus_wdata[NUM_LINES-1:0]));

    a_r3_data_write_ignored: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> ($stable(pin_out) && $stable(pin_oe) && $stable(mask_q)));

    a_r7_masked_silent: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (irq_o == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
    localparam int N  = 32;
    localparam int NI = 4;
    localparam int SN = 12;
    localparam int SI = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [N-1:0] pin_in = 0, pin_out, pin_oe;
    logic [NI-1:0] irq_o;

    logic        s_valid = 0, s_write = 0;
    logic [7:0]  s_addr = 0;
    logic [31:0] s_wdata = 0, s_rdata;
    logic [SN-1:0] s_pin_in = 0, s_pin_out, s_pin_oe;
    logic [SI-1:0] s_irq;

    gpio_irq_ctrl #(.NUM_LINES(N), .NUM_IRQ(NI), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    gpio_irq_ctrl #(.NUM_LINES(SN), .NUM_IRQ(SI), .ADDR_W(8)) dut_s (
        .clk(clk), .rst(rst), .bus_valid(s_valid), .bus_write(s_write),
        .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
        .pin_in(s_pin_in), .pin_out(s_pin_out), .pin_oe(s_pin_oe), .irq_o(s_irq)
    );

    int checks = 0, fails = 0;

    // bench model
    logic [N-1:0] m_mask = 0, m_pol = 0, m_edge = 0;
    logic         m_en  [N];
    logic [4:0]   m_idx [N];
    logic [N-1:0] m_s1 = 0, m_s2 = 0, m_prev = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    function automatic logic [NI-1:0] exp_irq();
        logic [NI-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            logic c, p, hit;
            c = m_s2[i]; p = m_prev[i];
            if (m_edge[i]) hit = m_pol[i] ? (c & ~p) : (~c & p);
            else           hit = m_pol[i] ? c : ~c;
            if (m_mask[i] && hit && m_en[i] && m_idx[i] < NI) r[m_idx[i]] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
        case (a)
            8'h0C: m_mask = d;
            8'h10: m_pol  = d;
            8'h14: m_edge = d;
            default: if (a >= 8'h20 && a < 8'h40 && a[1:0] == 0)
                for (int k = 0; k < 4; k++) begin
                    m_en [(a - 8'h20) + k] = d[k*8 + 7];
                    m_idx[(a - 8'h20) + k] = d[k*8 +: 5];
                end
        endcase
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic s_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        s_valid = 1; s_write = 1; s_addr = a; s_wdata = d;
        @(posedge clk); #1;
        s_valid = 0; s_write = 0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < N; i++) begin m_en[i] = 0; m_idx[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        bus_rd(8'h0C, rd); check("R1 mask", rd, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 irq_o", 32'(irq_o), 0);
        bus_rd(8'h20, rd); check("R1 route", rd, 0);

        // R2 output and direction
        bus_wr(8'h04, 32'h1234_5678);
        bus_wr(8'h08, 32'hFF00_FF00);
        @(negedge clk);
        check("R2 pin_out", pin_out, 32'h1234_5678);
        check("R2 pin_oe", pin_oe, 32'hFF00_FF00);
        bus_rd(8'h08, rd); check("R2 dir readback", rd, 32'hFF00_FF00);

        // R3 synchronizer latency and ignored write
        bus_addr = 8'h00;
        @(negedge clk); pin_in = 32'hA5A5_0F0F;
        @(negedge clk); check("R3 one edge", bus_rdata, 0);
        @(negedge clk); check("R3 two edges", bus_rdata, 32'hA5A5_0F0F);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_rd(8'h00, rd); check("R3 write ignored data", rd, 32'hA5A5_0F0F);
        check("R3 write ignored out", pin_out, 32'h1234_5678);
        check("R3 write ignored oe", pin_oe, 32'hFF00_FF00);

        // R10 unmapped
        bus_rd(8'h18, rd); check("R10 0x18", rd, 0);
        bus_rd(8'h1C, rd); check("R10 0x1C", rd, 0);
        bus_rd(8'h40, rd); check("R10 0x40", rd, 0);

        // R8 routing byte layout and readback
        bus_wr(8'h20, 32'hE383_0281);
        bus_rd(8'h20, rd); check("R8 route readback", rd, 32'h8383_0281);

        // R6 rising edge pulse: line 5 -> irq 0
        @(negedge clk); pin_in = 0;
        repeat (3) @(negedge clk);
        bus_wr(8'h24, 32'h0000_8000);  // line5 byte1: en idx0
        bus_wr(8'h10, 32'h0000_0020);
        bus_wr(8'h14, 32'h0000_0020);
        bus_wr(8'h0C, 32'h0000_0020);
        @(negedge clk); check("R6 idle", 32'(irq_o), 0);
        pin_in[5] = 1;
        @(negedge clk); check("R6 after one edge", 32'(irq_o), 0);
        @(negedge clk); check("R6 pulse", 32'(irq_o), 1);
        @(negedge clk); check("R6 pulse ends", 32'(irq_o), 0);

        // R5 level high on line 5
        bus_wr(8'h14, 32'h0);
        @(negedge clk); check("R5 level high held", 32'(irq_o), 1);
        @(negedge clk); check("R5 level high still", 32'(irq_o), 1);
        // R7 masking
        bus_wr(8'h0C, 32'h0);
        @(negedge clk); check("R7 masked", 32'(irq_o), 0);

        // random phase: R5 R6 R7 R8 R9 against model
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 7) == 0) begin
                int sel = $urandom_range(0, 5);
                logic [31:0] d = $urandom;
                if (sel < 3) bus_wr(8'h0C + 8'(sel * 4), d);
                else begin
                    for (int b = 0; b < 4; b++) d[b*8 +: 8] = {d[b*8+7], 2'b00, 2'b00, d[b*8 +: 3]};
                    bus_wr(8'h20 + 8'($urandom_range(0, 7) * 4), d);
                end
            end
            @(negedge clk);
            check("R8 random route/trigger", 32'(irq_o), 32'(exp_irq()));
            if ($urandom_range(0, 2) == 0) pin_in = pin_in ^ ($urandom & $urandom);
        end

        // small instance: R4 and R9
        s_wr(8'h04, 32'hFFFF_FFFF);
        s_addr = 8'h04; #1; check("R4 bits above lines", s_rdata, 32'h0000_0FFF);
        s_wr(8'h20, 32'h0000_0083);   // line0 en idx3 >= NUM_IRQ
        s_wr(8'h10, 32'h1);
        s_wr(8'h0C, 32'h1);
        @(negedge clk); s_pin_in[0] = 1;
        repeat (3) @(negedge clk);
        check("R9 index out of range", 32'(s_irq), 0);
        s_wr(8'h20, 32'h0000_0001);   // enable clear
        @(negedge clk); check("R9 route disabled", 32'(s_irq), 0);
        s_wr(8'h20, 32'h0000_0081);
        @(negedge clk); check("R8 small routed", 32'(s_irq), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule